// File: doc/BRIEF.md
# Railroad Crossing Gate and Signal Controller

This block supervises a single-direction level crossing. Two sensors at the edges of the guarded region send one-cycle pulses when a train enters and when it leaves. A one-second strobe (`tick`) drives every timer. The gate mechanism confirms each completed raise or lower with an acknowledge pulse. On every entry the controller lowers the gate. It times the train's 6-second approach to the stop signal and shows "pass" only once the gate is confirmed down. After the region has stayed empty for 10 whole seconds it raises the gate again.

The controller also checks at runtime that its environment keeps its promises. A six-bit sticky fault vector records each broken assumption: trains entering too close together, a transit time outside its window, two trains in the region at once, an exit from an empty region, a gate movement that takes too long, and a train held at the signal too long. The faults clear only on reset.

Top module: `rail_xing_ctrl`

## Requirements
- R1: After synchronous reset the signal shows stop (`sig_pass`=0), neither gate command is active, all `fault` bits are 0, the region counts as empty and the gate is taken to be open.
- R2: An entry pulse while the gate is open or rising asserts `gate_lower` on the next cycle, and it stays asserted until `gate_down_done`. `gate_lower` and `gate_raise` are never both high. The train reaches the signal on the 6th tick after its entry. `sig_pass` rises one cycle after the train has arrived and the gate is down, and never earlier.
- R3: While `sig_pass` is high, the next tick counts as the train passing the signal. `sig_pass` then drops to 0 on that edge and the transit timer starts from 0.
- R4: Once the gate is down and the region is empty, `gate_raise` asserts on the tick that completes 10 consecutive empty ticks. It stays high until `gate_up_done`, when the gate is taken to be open.
- R5: `fault[0]` sets when an entry arrives fewer than 40 ticks after the previous entry. An entry 40 or more ticks later does not set it.
- R6: `fault[1]` sets when a train that has passed the signal exits after fewer than 15 or more than 25 ticks, counted from the passing tick. Any value from 15 to 25 is legal.
- R7: Occupancy counts entries minus exits and saturates at 2. An entry and an exit in the same cycle leave it unchanged. `fault[2]` sets when the count reaches 2.
- R8: An exit with no train counted (and no simultaneous entry) sets `fault[3]`, and the count stays at 0.
- R9: `fault[4]` sets on the 10th tick of a gate lowering or raising that has not been acknowledged.
- R10: `fault[5]` sets on the 10th tick after a train's arrival at the signal if the signal still shows stop.
- R11: Every `fault` bit, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe once per second |
| trn_enter | input | 1 | Pulse: a train crossed the entry sensor |
| trn_exit | input | 1 | Pulse: a train crossed the exit sensor |
| gate_up_done | input | 1 | Pulse: gate raise completed |
| gate_down_done | input | 1 | Pulse: gate lower completed |
| sig_pass | output | 1 | 1 = signal shows pass, 0 = stop |
| gate_raise | output | 1 | Raise command, held until acknowledged |
| gate_lower | output | 1 | Lower command, held until acknowledged |
| fault | output | 6 | Sticky faults: [0] spacing, [1] transit, [2] two trains, [3] exit underflow, [4] gate timeout, [5] release late |

## Verification
The bound checker evaluates several properties on every cycle. It checks that the two gate commands never overlap, that pass is never shown while the gate moves, that an entry during a raise reverses the gate, that an occupancy of two always carries its fault bit, and that no fault bit ever clears. The exact tick on which each timer fires can only be shown by the bench's scenarios, which place events just before and just after each limit. These timers cover the arrival at the signal, the empty-region reopening, the 40-tick spacing, the 15–25 transit window and the two 10-tick timeouts.

// File: rtl/xing_pkg.sv
package xing_pkg;

    typedef enum logic [1:0] {
        G_OPEN,
        G_LOWERING,
        G_CLOSED,
        G_RAISING
    } gate_st_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_APPROACH,
        T_AT_SIGNAL,
        T_PASSED
    } trk_st_e;

    // Bit order is visible at the fault port: [5] .. [0]
    typedef struct packed {
        logic release_late;
        logic gate_timeout;
        logic underflow;
        logic overlap;
        logic transit;
        logic spacing;
    } fault_t;

    localparam int FAULT_W = $bits(fault_t);

    function automatic logic outside_window(input int v, input int lo, input int hi);
        return (v < lo) || (v > hi);
    endfunction

endpackage

// File: rtl/xing_occupancy.sv
module xing_occupancy (
    input  logic       clk,
    input  logic       rst,
    input  logic       enter,
    input  logic       leave,
    output logic [1:0] occ,
    output logic       occ_zero,
    output logic       overlap_ev,
    output logic       underflow_ev
);
    localparam logic [1:0] OCC_MAX = 2'd2;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            case ({enter, leave})
                2'b10:   if (occ != OCC_MAX) occ <= occ + 2'd1;
                2'b01:   if (occ != 2'd0)    occ <= occ - 2'd1;
                default: occ <= occ;
            endcase
        end
    end

    assign occ_zero     = (occ == 2'd0);
    assign overlap_ev   = enter && !leave && (occ == OCC_MAX - 2'd1);
    assign underflow_ev = leave && !enter && (occ == 2'd0);
endmodule

// File: rtl/xing_spacing.sv
module xing_spacing #(
    parameter int GAP_TICKS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic enter,
    output logic spacing_ev
);
    localparam int W = $clog2(GAP_TICKS + 1);
    localparam logic [W-1:0] GAP_FULL = W'(GAP_TICKS);

    logic         seen;
    logic [W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            gap  <= '0;
        end else if (enter) begin
            seen <= 1'b1;
            gap  <= '0;
        end else if (tick && gap != GAP_FULL) begin
            gap <= gap + 1'b1;
        end
    end

    assign spacing_ev = enter && seen && (gap < GAP_FULL);
endmodule

// File: rtl/xing_train.sv
module xing_train
    import xing_pkg::*;
#(
    parameter int ARRIVE_TICKS  = 6,
    parameter int RELEASE_TICKS = 10,
    parameter int TRANSIT_MIN   = 15,
    parameter int TRANSIT_MAX   = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic enter,
    input  logic leave,
    input  logic gate_closed,
    output logic sig_pass,
    output logic transit_ev,
    output logic release_ev
);
    // one shared counter; arrival and release limits must not exceed CMAX
    localparam int CMAX = TRANSIT_MAX + 1;
    localparam int W    = $clog2(CMAX + 1);
    localparam logic [W-1:0] C_FULL   = W'(CMAX);
    localparam logic [W-1:0] ARR_LAST = W'(ARRIVE_TICKS - 1);
    localparam logic [W-1:0] REL_LAST = W'(RELEASE_TICKS - 1);

    trk_st_e      st;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= T_IDLE;
            cnt      <= '0;
            sig_pass <= 1'b0;
        end else if (enter) begin
            st       <= T_APPROACH;
            cnt      <= '0;
            sig_pass <= 1'b0;
        end else begin
            case (st)
                T_APPROACH: if (tick) begin
                    if (cnt == ARR_LAST) begin
                        st  <= T_AT_SIGNAL;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                T_AT_SIGNAL: begin
                    if (tick && sig_pass) begin
                        st       <= T_PASSED;
                        cnt      <= '0;
                        sig_pass <= 1'b0;
                    end else begin
                        if (gate_closed)           sig_pass <= 1'b1;
                        if (tick && cnt != C_FULL) cnt      <= cnt + 1'b1;
                    end
                end
                T_PASSED: begin
                    if (leave) begin
                        st  <= T_IDLE;
                        cnt <= '0;
                    end else if (tick && cnt != C_FULL) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign transit_ev = leave && (st == T_PASSED) &&
                        outside_window(int'(cnt), TRANSIT_MIN, TRANSIT_MAX);
    assign release_ev = (st == T_AT_SIGNAL) && tick && !sig_pass && (cnt == REL_LAST);
endmodule

// File: rtl/xing_gate.sv
module xing_gate
    import xing_pkg::*;
#(
    parameter int EMPTY_TICKS = 10,
    parameter int GATE_TICKS  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic enter,
    input  logic occ_zero,
    input  logic up_done,
    input  logic dn_done,
    output logic gate_lower,
    output logic gate_raise,
    output logic gate_closed,
    output logic timeout_ev
);
    localparam int EW = $clog2(EMPTY_TICKS + 1);
    localparam int GW = $clog2(GATE_TICKS + 1);
    localparam logic [EW-1:0] E_FULL = EW'(EMPTY_TICKS);
    localparam logic [EW-1:0] E_LAST = EW'(EMPTY_TICKS - 1);
    localparam logic [GW-1:0] G_FULL = GW'(GATE_TICKS);
    localparam logic [GW-1:0] G_LAST = GW'(GATE_TICKS - 1);

    gate_st_e      st;
    logic [EW-1:0] ecnt;
    logic [GW-1:0] op;
    logic          raise_go;

    always_ff @(posedge clk) begin
        if (rst || enter || !occ_zero)      ecnt <= '0;
        else if (tick && ecnt != E_FULL)    ecnt <= ecnt + 1'b1;
    end

    always_comb begin
        raise_go   = occ_zero && !enter && (ecnt == E_FULL || (tick && ecnt == E_LAST));
        timeout_ev = 1'b0;
        if (tick && op == G_LAST) begin
            if (st == G_LOWERING && !dn_done)           timeout_ev = 1'b1;
            if (st == G_RAISING && !up_done && !enter)  timeout_ev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= G_OPEN;
            op <= '0;
        end else begin
            case (st)
                G_OPEN: if (enter) begin
                    st <= G_LOWERING;
                    op <= '0;
                end
                G_LOWERING: begin
                    if (dn_done)                    st <= G_CLOSED;
                    else if (tick && op != G_FULL)  op <= op + 1'b1;
                end
                G_CLOSED: if (raise_go) begin
                    st <= G_RAISING;
                    op <= '0;
                end
                default: begin
                    if (enter) begin
                        st <= G_LOWERING;
                        op <= '0;
                    end else if (up_done) begin
                        st <= G_OPEN;
                    end else if (tick && op != G_FULL) begin
                        op <= op + 1'b1;
                    end
                end
            endcase
        end
    end

    assign gate_lower  = (st == G_LOWERING);
    assign gate_raise  = (st == G_RAISING);
    assign gate_closed = (st == G_CLOSED);
endmodule

// File: rtl/rail_xing_ctrl.sv
module rail_xing_ctrl
    import xing_pkg::*;
#(
    parameter int ARRIVE_TICKS  = 6,
    parameter int RELEASE_TICKS = 10,
    parameter int EMPTY_TICKS   = 10,
    parameter int GAP_TICKS     = 40,
    parameter int TRANSIT_MIN   = 15,
    parameter int TRANSIT_MAX   = 25,
    parameter int GATE_TICKS    = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               trn_enter,
    input  logic               trn_exit,
    input  logic               gate_up_done,
    input  logic               gate_down_done,
    output logic               sig_pass,
    output logic               gate_raise,
    output logic               gate_lower,
    output logic [FAULT_W-1:0] fault
);
    logic [1:0] occ;
    logic       occ_zero, gate_closed;
    fault_t     ev, fault_q;

    xing_occupancy occ_i (
        .clk(clk), .rst(rst), .enter(trn_enter), .leave(trn_exit),
        .occ(occ), .occ_zero(occ_zero),
        .overlap_ev(ev.overlap), .underflow_ev(ev.underflow)
    );

    xing_spacing #(.GAP_TICKS(GAP_TICKS)) spc_i (
        .clk(clk), .rst(rst), .tick(tick), .enter(trn_enter),
        .spacing_ev(ev.spacing)
    );

    xing_train #(
        .ARRIVE_TICKS(ARRIVE_TICKS), .RELEASE_TICKS(RELEASE_TICKS),
        .TRANSIT_MIN(TRANSIT_MIN), .TRANSIT_MAX(TRANSIT_MAX)
    ) trn_i (
        .clk(clk), .rst(rst), .tick(tick), .enter(trn_enter), .leave(trn_exit),
        .gate_closed(gate_closed), .sig_pass(sig_pass),
        .transit_ev(ev.transit), .release_ev(ev.release_late)
    );

    xing_gate #(.EMPTY_TICKS(EMPTY_TICKS), .GATE_TICKS(GATE_TICKS)) gate_i (
        .clk(clk), .rst(rst), .tick(tick), .enter(trn_enter), .occ_zero(occ_zero),
        .up_done(gate_up_done), .dn_done(gate_down_done),
        .gate_lower(gate_lower), .gate_raise(gate_raise),
        .gate_closed(gate_closed), .timeout_ev(ev.gate_timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) fault_q <= '0;
        else     fault_q <= fault_q | ev;
    end

    assign fault = fault_q;
endmodule

// File: rtl/rail_xing_ctrl_chk.sv
module rail_xing_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       trn_enter,
    input logic       sig_pass,
    input logic       gate_raise,
    input logic       gate_lower,
    input logic [5:0] fault,
    input logic [1:0] occ
);
    p_cmd_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(gate_lower && gate_raise));

    p_enter_reverses_r2: assert property (@(posedge clk) disable iff (rst)
        (trn_enter && gate_raise) |=> gate_lower);

    p_pass_gate_still_r3: assert property (@(posedge clk) disable iff (rst)
        sig_pass |-> (!gate_lower && !gate_raise));

    p_two_trains_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (occ == 2'd2) |-> fault[2]);

    p_fault_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(fault) & ~fault) == 6'd0);
endmodule

bind rail_xing_ctrl rail_xing_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .trn_enter(trn_enter), .sig_pass(sig_pass),
    .gate_raise(gate_raise), .gate_lower(gate_lower), .fault(fault), .occ(occ)
);

// File: tb/rail_xing_ctrl_tb_top.sv
`timescale 1ns/1ps
module rail_xing_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, trn_enter = 1'b0, trn_exit = 1'b0;
    logic       gate_up_done = 1'b0, gate_down_done = 1'b0;
    logic       sig_pass, gate_raise, gate_lower;
    logic [5:0] fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rail_xing_ctrl dut_i (
        .clk(clk), .rst(rst), .tick(tick), .trn_enter(trn_enter), .trn_exit(trn_exit),
        .gate_up_done(gate_up_done), .gate_down_done(gate_down_done),
        .sig_pass(sig_pass), .gate_raise(gate_raise), .gate_lower(gate_lower),
        .fault(fault)
    );

    // {req[3:0], idle ticks[7:0], tick,enter,exit,dn,up, exp pass,lower,raise, exp fault[5:0]}
    localparam int NV = 10;
    localparam logic [25:0] TBL [NV] = '{
        {4'd2,  8'd0,  5'b01000, 3'b010, 6'd0},  // R2 entry lowers gate
        {4'd2,  8'd0,  5'b00010, 3'b000, 6'd0},  // R2 down ack, still stop
        {4'd2,  8'd5,  5'b10000, 3'b000, 6'd0},  // R2 6th tick: arrival, pass not yet
        {4'd2,  8'd0,  5'b00000, 3'b100, 6'd0},  // R2 pass one cycle later
        {4'd3,  8'd0,  5'b10000, 3'b000, 6'd0},  // R3 next tick: train passes
        {4'd6,  8'd15, 5'b00100, 3'b000, 6'd0},  // R6 exit at 15 ticks legal
        {4'd4,  8'd8,  5'b10000, 3'b000, 6'd0},  // R4 9 empty ticks: no raise
        {4'd4,  8'd0,  5'b10000, 3'b001, 6'd0},  // R4 10th empty tick raises
        {4'd4,  8'd0,  5'b00001, 3'b000, 6'd0},  // R4 up ack
        {4'd5,  8'd8,  5'b01000, 3'b010, 6'd0}   // R5 entry 40 ticks later legal
    };

    task automatic step(input logic t, input logic en, input logic ex,
                        input logic dn, input logic up);
        tick = t; trn_enter = en; trn_exit = ex; gate_down_done = dn; gate_up_done = up;
        @(posedge clk);
        @(negedge clk);
        tick = 0; trn_enter = 0; trn_exit = 0; gate_down_done = 0; gate_up_done = 0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) step(1, 0, 0, 0, 0);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic transit_run(input int n, output logic flag);
        do_reset();
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        ticks(6);
        step(0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        ticks(n);
        step(0, 0, 1, 0, 0);
        flag = fault[1];
    endtask

    initial begin
        logic f;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1", "sig_pass", sig_pass, 0);
        chk("R1", "gate_lower", gate_lower, 0);
        chk("R1", "gate_raise", gate_raise, 0);
        chk("R1", "fault", fault, 0);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            string r;
            v = TBL[i];
            r = $sformatf("R%0d", v[25:22]);
            ticks(int'(v[21:14]));
            step(v[13], v[12], v[11], v[10], v[9]);
            chk(r, "sig_pass", sig_pass, v[8]);
            chk(r, "gate_lower", gate_lower, v[7]);
            chk(r, "gate_raise", gate_raise, v[6]);
            chk(r, "fault", fault, v[5:0]);
        end

        // R5 / R7: second entry after 39 ticks
        do_reset();
        step(0, 1, 0, 0, 0);
        ticks(39);
        chk("R5", "fault[0] before", fault[0], 0);
        step(0, 1, 0, 0, 0);
        chk("R5", "fault[0]", fault[0], 1);
        chk("R7", "fault[2]", fault[2], 1);

        // R8: exit from empty region, count stays 0
        do_reset();
        step(0, 0, 1, 0, 0);
        chk("R8", "fault", fault, 6'b001000);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 1, 0, 0);
        ticks(9);
        chk("R8", "raise after 9", gate_raise, 0);
        ticks(1);
        chk("R8", "raise after 10", gate_raise, 1);
        chk("R8", "fault unchanged", fault, 6'b001000);

        // R6: window edges
        transit_run(14, f);
        chk("R6", "exit at 14", f, 1);
        transit_run(25, f);
        chk("R6", "exit at 25", f, 0);
        transit_run(26, f);
        chk("R6", "exit at 26", f, 1);

        // R9 / R10: gate never acknowledges
        do_reset();
        step(0, 1, 0, 0, 0);
        ticks(9);
        chk("R9", "fault[4] at 9", fault[4], 0);
        ticks(1);
        chk("R9", "fault[4] at 10", fault[4], 1);
        ticks(5);
        chk("R10", "fault[5] at 15", fault[5], 0);
        chk("R2", "no pass while lowering", sig_pass, 0);
        ticks(1);
        chk("R10", "fault[5] at 16", fault[5], 1);

        // R11: faults persist
        ticks(20);
        chk("R11", "fault[4] held", fault[4], 1);
        chk("R11", "fault[5] held", fault[5], 1);

        // R1: reset clears faults
        do_reset();
        chk("R1", "fault after reset", fault, 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule